// File: doc/BRIEF.md
# Warp Instruction Issue Scheduler

This block sits between instruction fetch and the execution lanes of a multithreaded processor core. It holds one buffered instruction per resident warp, a group of 32 threads that executes in lockstep. Each cycle it may pick one of those instructions and send it to a dispatch port, which then broadcasts it to all lanes of the warp. Each buffered entry carries an opcode, one destination register ID and two source register IDs.

A per-warp register scoreboard prevents hazards. Issuing an instruction marks its destination register pending for that warp. A writeback port clears the mark. An entry competes for issue only when none of the three registers it names is pending for its own warp. The dispatch port stays occupied for several cycles per instruction, so a new issue can start only once the previous one has finished. Among the entries that can issue, the scheduler rotates through the warps, starting just after the warp that issued last. A warp that is waiting on a hazard therefore never holds back any other warp.

Fetch delivers at most one instruction per cycle. It checks `fetch_ready` for the warp it addresses, and it may write only into an empty slot.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is asserted, and on its release, every slot is empty, every scoreboard bit is clear and `issue_valid` is 0. The rotation then searches from warp 0 upward.
- R2: An instruction written by fetch at clock edge t can appear on the issue outputs after edge t+1 at the earliest, provided the port is free and it has no hazard. The issue outputs then carry its warp number, opcode, destination and both sources, with `issue_valid` high for one cycle.
- R3: `fetch_ready` is high exactly when the addressed slot is empty. A fetch to an occupied slot is dropped and leaves the held instruction unchanged. A slot becomes empty at the edge where its instruction issues.
- R4: An entry is not issued while its first source, second source or destination register is pending for its warp.
- R5: Issuing an instruction marks its destination pending for its warp. A writeback sampled at edge t clears the bit, so a waiting instruction can issue at edge t+1 at the earliest and not at edge t.
- R6: The scoreboard is separate per warp: a writeback to register r of one warp does not release a hazard on register r of another warp.
- R7: Two issues are at least ISSUE_CYCLES cycles apart. With eligible work always waiting, they are exactly ISSUE_CYCLES cycles apart.
- R8: The scheduler issues the first eligible warp found by ascending warp number after the warp that issued last, wrapping from the highest warp to warp 0. This order depends neither on fetch order nor on the lowest warp number.
- R9: A warp stalled on a hazard does not delay the issue of an eligible warp once the port is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_valid | input | 1 | Fetch presents an instruction this cycle |
| fetch_warp | input | WID_W | Warp slot the fetch targets |
| fetch_opc | input | OPC_W | Opcode of the fetched instruction |
| fetch_dst | input | RID_W | Destination register ID |
| fetch_src0 | input | RID_W | First source register ID |
| fetch_src1 | input | RID_W | Second source register ID |
| fetch_ready | output | 1 | Addressed slot is empty and can accept the fetch |
| wb_valid | input | 1 | A register writeback completes this cycle |
| wb_warp | input | WID_W | Warp of the writeback |
| wb_reg | input | RID_W | Register written back |
| issue_valid | output | 1 | One-cycle pulse: an instruction starts on the dispatch port |
| issue_warp | output | WID_W | Warp of the issued instruction |
| issue_opc | output | OPC_W | Opcode of the issued instruction |
| issue_dst | output | RID_W | Destination register of the issued instruction |
| issue_src0 | output | RID_W | First source of the issued instruction |
| issue_src1 | output | RID_W | Second source of the issued instruction |

## Verification
The bench sweeps every warp of a four-warp setup against a hazard on each of the three operand positions in turn. A design that left out the destination check would issue the write-after-write case early. A design that cleared the scoreboard combinationally would issue one edge too soon after the writeback. A design that shared bits across warps would release the stall on a writeback to a different warp.

Fetches are also aimed at a slot that is already full. A design that overwrote the slot would issue the wrong opcode, and a design that queued the fetch would issue an extra instruction.

Warps are fetched out of order to check the rotation. A lowest-number-first arbiter, or one that follows fetch order, would produce a different warp sequence. Issue spacing is measured in cycles, so an off-by-one in the port occupancy counter shows up as a gap of 3 or 5.

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS    = 24,
  parameter int NUM_REGS     = 32,
  parameter int OPC_W        = 8,
  parameter int ISSUE_CYCLES = 4,
  localparam int WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int RID_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [WID_W-1:0] fetch_warp,
  input  logic [OPC_W-1:0] fetch_opc,
  input  logic [RID_W-1:0] fetch_dst,
  input  logic [RID_W-1:0] fetch_src0,
  input  logic [RID_W-1:0] fetch_src1,
  output logic             fetch_ready,
  input  logic             wb_valid,
  input  logic [WID_W-1:0] wb_warp,
  input  logic [RID_W-1:0] wb_reg,
  output logic             issue_valid,
  output logic [WID_W-1:0] issue_warp,
  output logic [OPC_W-1:0] issue_opc,
  output logic [RID_W-1:0] issue_dst,
  output logic [RID_W-1:0] issue_src0,
  output logic [RID_W-1:0] issue_src1
);

  localparam int CNT_W = $clog2(ISSUE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ISSUE_CYCLES - 1);

  logic [NUM_WARPS-1:0]                slot_valid;
  logic [OPC_W-1:0]                    slot_opc [NUM_WARPS];
  logic [RID_W-1:0]                    slot_dst [NUM_WARPS];
  logic [RID_W-1:0]                    slot_s0  [NUM_WARPS];
  logic [RID_W-1:0]                    slot_s1  [NUM_WARPS];
  logic [NUM_WARPS-1:0][NUM_REGS-1:0]  pend;
  logic [NUM_WARPS-1:0]                elig;
  logic [WID_W-1:0]                    last_warp, sel_warp;
  logic                                sel_found, do_issue;
  logic [CNT_W-1:0]                    busy_cnt;

  wire fetch_in_range = {1'b0, fetch_warp} < (WID_W+1)'(NUM_WARPS);
  wire wb_in_range    = {1'b0, wb_warp}    < (WID_W+1)'(NUM_WARPS);

  assign fetch_ready = fetch_in_range && !slot_valid[fetch_warp];

  for (genvar g = 0; g < NUM_WARPS; g++) begin : g_elig
    assign elig[g] = slot_valid[g] && !pend[g][slot_s0[g]] &&
                     !pend[g][slot_s1[g]] && !pend[g][slot_dst[g]];
  end

  always_comb begin
    int idx;
    sel_found = 1'b0;
    sel_warp  = '0;
    for (int k = 1; k <= NUM_WARPS; k++) begin
      idx = int'(last_warp) + k;
      if (idx >= NUM_WARPS) idx = idx - NUM_WARPS;
      if (!sel_found && elig[idx]) begin
        sel_found = 1'b1;
        sel_warp  = WID_W'(idx);
      end
    end
  end

  assign do_issue = (busy_cnt == '0) && sel_found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_valid  <= '0;
      pend        <= '0;
      last_warp   <= WID_W'(NUM_WARPS - 1);
      busy_cnt    <= '0;
      issue_valid <= 1'b0;
      issue_warp  <= '0;
      issue_opc   <= '0;
      issue_dst   <= '0;
      issue_src0  <= '0;
      issue_src1  <= '0;
      for (int i = 0; i < NUM_WARPS; i++) begin
        slot_opc[i] <= '0;
        slot_dst[i] <= '0;
        slot_s0[i]  <= '0;
        slot_s1[i]  <= '0;
      end
    end else begin
      issue_valid <= do_issue;
      if (busy_cnt != '0) busy_cnt <= busy_cnt - CNT_W'(1);
      if (fetch_valid && fetch_ready) begin
        slot_valid[fetch_warp] <= 1'b1;
        slot_opc[fetch_warp]   <= fetch_opc;
        slot_dst[fetch_warp]   <= fetch_dst;
        slot_s0[fetch_warp]    <= fetch_src0;
        slot_s1[fetch_warp]    <= fetch_src1;
      end
      if (wb_valid && wb_in_range) pend[wb_warp][wb_reg] <= 1'b0;
      if (do_issue) begin
        busy_cnt                      <= CNT_LOAD;
        last_warp                     <= sel_warp;
        slot_valid[sel_warp]          <= 1'b0;
        pend[sel_warp][slot_dst[sel_warp]] <= 1'b1;
        issue_warp                    <= sel_warp;
        issue_opc                     <= slot_opc[sel_warp];
        issue_dst                     <= slot_dst[sel_warp];
        issue_src0                    <= slot_s0[sel_warp];
        issue_src1                    <= slot_s1[sel_warp];
      end
    end
  end

  // R7: a busy dispatch port admits no new issue
  p_port_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_cnt != '0) |=> !issue_valid);

  // R5: the issued destination is marked pending for its warp
  p_dst_marked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> pend[issue_warp][issue_dst]);

  // R3: an issued slot is empty afterwards
  p_slot_freed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !slot_valid[issue_warp]);

  // R5: a writeback clears its bit unless an issue re-marks it at that edge
  p_wb_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_in_range &&
     !(do_issue && sel_warp == wb_warp && slot_dst[sel_warp] == wb_reg))
    |=> !pend[$past(wb_warp)][$past(wb_reg)]);

  // R3: a dropped fetch leaves the slot occupied
  p_fetch_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_in_range && !fetch_ready &&
     !(do_issue && sel_warp == fetch_warp))
    |=> slot_valid[$past(fetch_warp)]);

endmodule

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;
  localparam int NW = 4;
  localparam int NR = 8;
  localparam int OW = 8;
  localparam int IC = 4;
  localparam int WW = $clog2(NW);
  localparam int RW = $clog2(NR);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0;
  logic [WW-1:0] fetch_warp = '0;
  logic [OW-1:0] fetch_opc = '0;
  logic [RW-1:0] fetch_dst = '0, fetch_src0 = '0, fetch_src1 = '0;
  logic fetch_ready;
  logic wb_valid = 1'b0;
  logic [WW-1:0] wb_warp = '0;
  logic [RW-1:0] wb_reg = '0;
  logic issue_valid;
  logic [WW-1:0] issue_warp;
  logic [OW-1:0] issue_opc;
  logic [RW-1:0] issue_dst, issue_src0, issue_src1;

  warp_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .OPC_W(OW), .ISSUE_CYCLES(IC)) dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_warp(fetch_warp), .fetch_opc(fetch_opc),
    .fetch_dst(fetch_dst), .fetch_src0(fetch_src0), .fetch_src1(fetch_src1),
    .fetch_ready(fetch_ready),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_opc(issue_opc),
    .issue_dst(issue_dst), .issue_src0(issue_src0), .issue_src1(issue_src1));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_iss = 0;
  int iss_cyc [256];
  int iss_warp[256];
  int iss_opc [256];
  always @(negedge clk) begin
    if (rst_n && issue_valid && n_iss < 256) begin
      iss_cyc[n_iss]  = cyc;
      iss_warp[n_iss] = int'(issue_warp);
      iss_opc[n_iss]  = int'(issue_opc);
      n_iss = n_iss + 1;
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fetch_valid = 1'b0;
    wb_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_fetch(input int w, input int o, input int d, input int s0, input int s1);
    fetch_valid = 1'b1;
    fetch_warp = WW'(w);
    fetch_opc = OW'(o);
    fetch_dst = RW'(d);
    fetch_src0 = RW'(s0);
    fetch_src1 = RW'(s1);
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int base;
    int bd, b0, b1, bo;
    bit ok;
    @(negedge clk);
    // R1: reset state
    chk(issue_valid == 1'b0, "R1", "issue_valid in reset", int'(issue_valid), 0);
    do_reset();
    ok = 1'b1;
    for (int w = 0; w < NW; w++) begin
      fetch_warp = WW'(w);
      #0.1;
      if (!fetch_ready) ok = 1'b0;
    end
    chk(ok, "R1", "all slots empty after reset", int'(ok), 1);
    base = n_iss;
    repeat (5) @(negedge clk);
    chk(n_iss == base, "R1", "no issue from empty buffer", n_iss - base, 0);

    // R1: reset clears a pending register
    do_fetch(1, 8'h31, 5, 0, 0);
    @(negedge clk);
    do_fetch(1, 8'h32, 2, 5, 0);
    repeat (6) @(negedge clk);
    do_reset();
    base = n_iss;
    do_fetch(1, 8'h33, 2, 5, 0);
    @(negedge clk);
    chk(issue_valid && issue_opc == 8'h33, "R1", "scoreboard cleared by reset", int'(issue_opc), 8'h33);

    // R4 R5 R6 R3 R2: hazard sweep over every warp and operand position
    for (int w = 0; w < NW; w++) begin
      for (int p = 0; p < 3; p++) begin
        do_reset();
        base = n_iss;
        do_fetch(w, 8'h10 + w, 5, 0, 0);
        @(negedge clk);
        chk(issue_valid && int'(issue_warp) == w && issue_dst == 5 && issue_opc == OW'(8'h10 + w),
            "R2", "first issue fields", int'(issue_warp), w);
        bd = (p == 2) ? 5 : 3;
        b0 = (p == 0) ? 5 : 1;
        b1 = (p == 1) ? 5 : 2;
        bo = 8'h40 + w * 4 + p;
        do_fetch(w, bo, bd, b0, b1);
        fetch_warp = WW'(w);
        #0.1;
        chk(!fetch_ready, "R3", "occupied slot not ready", int'(fetch_ready), 0);
        fetch_valid = 1'b1;
        fetch_opc = 8'hEE;
        wb_valid = 1'b1;
        wb_warp = WW'((w + 1) % NW);
        wb_reg = 5;
        @(negedge clk);
        fetch_valid = 1'b0;
        wb_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk(n_iss == base + 1, "R4", "hazard holds issue (R6 other-warp writeback)", n_iss - base, 1);
        wb_valid = 1'b1;
        wb_warp = WW'(w);
        wb_reg = 5;
        @(negedge clk);
        wb_valid = 1'b0;
        chk(!issue_valid, "R5", "no issue at writeback edge", int'(issue_valid), 0);
        @(negedge clk);
        chk(issue_valid && int'(issue_warp) == w && int'(issue_opc) == bo && int'(issue_dst) == bd &&
            int'(issue_src0) == b0 && int'(issue_src1) == b1,
            "R5", "issue one edge after writeback", int'(issue_opc), bo);
        repeat (6) @(negedge clk);
        chk(n_iss == base + 2, "R3", "dropped fetch never issues", n_iss - base, 2);
      end
    end

    // R9 R7: stalled warp 0 does not block warp 1
    do_reset();
    base = n_iss;
    do_fetch(0, 8'h11, 5, 0, 0);
    @(negedge clk);
    do_fetch(0, 8'h12, 3, 5, 1);
    do_fetch(1, 8'h21, 4, 0, 0);
    repeat (6) @(negedge clk);
    chk(n_iss == base + 2, "R9", "issue count with stalled warp", n_iss - base, 2);
    chk(iss_warp[base + 1] == 1 && iss_opc[base + 1] == 8'h21, "R9", "eligible warp issued", iss_warp[base + 1], 1);
    chk(iss_cyc[base + 1] - iss_cyc[base] == IC, "R7", "spacing", iss_cyc[base + 1] - iss_cyc[base], IC);

    // R8 R7: rotation with out-of-order fetch 2,0,3,1
    do_reset();
    base = n_iss;
    do_fetch(2, 8'h82, 6, 0, 0);
    do_fetch(0, 8'h80, 6, 0, 0);
    do_fetch(3, 8'h83, 6, 0, 0);
    do_fetch(1, 8'h81, 6, 0, 0);
    repeat (16) @(negedge clk);
    chk(n_iss == base + 4, "R8", "rotation issue count", n_iss - base, 4);
    begin
      int exp_w[4] = '{2, 3, 0, 1};
      for (int i = 0; i < 4; i++) begin
        chk(iss_warp[base + i] == exp_w[i] && iss_opc[base + i] == 8'h80 + exp_w[i],
            "R8", "rotation order", iss_warp[base + i], exp_w[i]);
        if (i > 0)
          chk(iss_cyc[base + i] - iss_cyc[base + i - 1] == IC, "R7", "back-to-back spacing",
              iss_cyc[base + i] - iss_cyc[base + i - 1], IC);
      end
    end

    // R8: wrap from the highest warp back to warp 0
    do_reset();
    base = n_iss;
    do_fetch(3, 8'h93, 7, 0, 0);
    do_fetch(2, 8'h92, 7, 0, 0);
    do_fetch(0, 8'h90, 7, 0, 0);
    repeat (12) @(negedge clk);
    chk(n_iss == base + 3 && iss_warp[base + 1] == 0 && iss_warp[base + 2] == 2,
        "R8", "wrap after warp 3", iss_warp[base + 1], 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule